// File: doc/BRIEF.md
# Quad Wiper Register Controller

This block controls four resistor-ladder tap selectors from a serial peripheral interface slave port. Each channel keeps a volatile wiper code of `WBITS` bits (six by default, so 64 taps) and a bank of four stored settings that stand in for nonvolatile cells. Serial commands read and write the wiper codes and the stored settings. Other commands copy a stored setting into a wiper, save a wiper into a stored setting, or load every wiper from the same stored slot at once. The stored array keeps its contents through reset. The analog switches are outside the block. It drives one binary code and one one-hot tap select per channel.

Every frame has three bytes and is clocked in on the rising edge of SCK. Read data goes out on the falling edge, so SPI mode 0 and mode 3 both work. SCK, chip select, hold and MOSI are taken into the system clock domain through a two-flop synchronizer. The serial clock must therefore run well below the system clock. A stored write or save keeps the stored array busy for `BUSY_CYCLES` clocks. A write-protect pin blocks stored writes and saves.

Top module: `quad_wiper_ctrl`

## Requirements
- R1: While `rst` is high, every wiper code is loaded from stored slot 0 of its own channel. With no writes, all stored slots hold `NV_INIT` (32 by default). The stored contents are unchanged by reset.
- R2: Frame byte 1 is `[7:4]` = device code 0101, `[3:2]` = must equal `dev_addr`, `[1:0]` = channel. Byte 2 is `[7:4]` = opcode, `[1:0]` = slot. Byte 3 is `[5:0]` = data. Bits go MSB first. A frame whose device code or address does not match changes nothing and never raises `spi_miso_oe`.
- R3: Opcode 1010 writes byte-3 data into the channel's wiper. Opcode 1001 returns that wiper as byte 3 in the form `{2'b00, code}`, MSB first.
- R4: Opcode 1100 writes byte-3 data into the stored slot of the channel. Opcode 1011 returns that stored slot as byte 3. A stored write leaves the wiper as it was.
- R5: Opcode 1101 copies the channel's stored slot into its wiper. Opcode 1110 saves the channel's wiper into its stored slot.
- R6: Opcode 0001 loads every channel's wiper from stored slot n, where n is the slot field. The channel field is ignored.
- R7: While `wp_n` is low, stored writes (1100) and saves (1110) are discarded and do not start a busy period. Wiper writes still take effect.
- R8: An accepted stored write or save raises `nv_busy` for `BUSY_CYCLES` clocks. Stored writes and saves that arrive while `nv_busy` is high are discarded.
- R9: While `spi_hold_n` is low, SCK edges are ignored and `spi_miso_oe` is low. The partial frame resumes intact once hold is released.
- R10: A frame takes effect at its 24th rising SCK edge. If chip select goes high before that edge, the frame is dropped with no register change.
- R11: Frames work in both mode 0 (SCK idle low) and mode 3 (SCK idle high). MOSI is sampled on rising edges and MISO changes on falling edges.
- R12: `wiper_codes[c*WBITS +: WBITS]` is channel c's code. `tap_sel[c*2**WBITS +: 2**WBITS]` has exactly one bit set, at the position of that code. Codes 0 and 63 are both valid.
- R13: An opcode outside the seven listed above changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; reloads wipers from slot 0 |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Pauses the serial port when low |
| wp_n | input | 1 | Write protect for stored slots, active low |
| dev_addr | input | 2 | Device address strap compared with byte 1 bits 3:2 |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (low means high impedance) |
| nv_busy | output | 1 | Stored array write in progress |
| wiper_codes | output | NCH*WBITS | Wiper codes, channel 0 in the low bits |
| tap_sel | output | NCH*2**WBITS | One-hot tap select per channel |

## Verification
Several behaviours are checked by assertions on every cycle. Each tap select must be one-hot and agree with its wiper code. Wiper codes must stay still in any cycle that follows no completed command, which covers aborted, mismatched and unknown frames. `spi_miso_oe` must stay low when chip select or hold has been inactive. A busy period may start only from a completed command with write protect released.

Other behaviours can only be shown by the bench's frames, in both serial modes. These are: the decoding of each opcode, read-back data, stored contents surviving reset, rejection during a busy period, and a frame resuming after hold.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    // Protocol constants (frame layout is fixed: 3 bytes)
    localparam logic [3:0] DEV_CODE    = 4'b0101;
    localparam int         FRAME_BITS  = 24;
    localparam int         DEF_NCH     = 4;
    localparam int         DEF_NSLOT   = 4;
    localparam int         DEF_WBITS   = 6;

    // Opcodes carried in byte 2 [7:4]
    localparam logic [3:0] OP_LOAD_ALL = 4'b0001;
    localparam logic [3:0] OP_RD_WIPER = 4'b1001;
    localparam logic [3:0] OP_WR_WIPER = 4'b1010;
    localparam logic [3:0] OP_RD_SLOT  = 4'b1011;
    localparam logic [3:0] OP_WR_SLOT  = 4'b1100;
    localparam logic [3:0] OP_RECALL   = 4'b1101;
    localparam logic [3:0] OP_SAVE     = 4'b1110;

    // Decoded command handed from the serial front end to the register bank
    typedef struct packed {
        logic [1:0] chan;
        logic [3:0] op;
        logic [1:0] slot;
        logic [5:0] data;
    } wpc_cmd_t;

    function automatic logic op_is_read(input logic [3:0] op);
        return (op == OP_RD_WIPER) || (op == OP_RD_SLOT);
    endfunction

    function automatic logic op_writes_slot(input logic [3:0] op);
        return (op == OP_WR_SLOT) || (op == OP_SAVE);
    endfunction

endpackage

// File: rtl/wpc_spi_front.sv
module wpc_spi_front
    import wpc_pkg::*;
#(
    parameter int WBITS = DEF_WBITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sck,
    input  logic             cs_n,
    input  logic             mosi,
    input  logic             hold_n,
    input  logic [1:0]       dev_addr,
    input  logic [WBITS-1:0] rd_data,
    output logic [1:0]       look_chan,
    output logic [3:0]       look_op,
    output logic [1:0]       look_slot,
    output logic             cmd_valid,
    output wpc_cmd_t         cmd,
    output logic             miso,
    output logic             miso_oe
);

    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] FULL      = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] BYTE1_END = CNT_W'(7);
    localparam logic [CNT_W-1:0] BYTE2_END = CNT_W'(15);
    localparam logic [CNT_W-1:0] BYTE3_BEG = CNT_W'(16);

    // Two-flop synchronizers; SCK keeps one extra stage for edge detection
    logic [2:0] sck_p;
    logic [1:0] cs_p, hold_p, mosi_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p  <= '0;
            cs_p   <= '1;
            hold_p <= '1;
            mosi_p <= '0;
        end else begin
            sck_p  <= {sck_p[1:0], sck};
            cs_p   <= {cs_p[0], cs_n};
            hold_p <= {hold_p[0], hold_n};
            mosi_p <= {mosi_p[0], mosi};
        end
    end

    logic sck_rise, sck_fall, active, run;
    assign sck_rise = sck_p[1] & ~sck_p[2];
    assign sck_fall = ~sck_p[1] & sck_p[2];
    assign active   = ~cs_p[1];
    assign run      = active & hold_p[1];

    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       sh_q, sh_nxt, rd_byte_q;
    logic             sel_q, miso_q;
    logic [1:0]       chan_q, slot_q;
    logic [3:0]       op_q;
    logic [2:0]       out_idx;

    assign sh_nxt  = {sh_q[6:0], mosi_p[1]};
    assign out_idx = 3'(cnt_q - BYTE3_BEG);

    // Lookup for read data is taken while byte 2 completes
    assign look_chan = chan_q;
    assign look_op   = sh_nxt[7:4];
    assign look_slot = sh_nxt[1:0];

    always_ff @(posedge clk) begin
        cmd_valid <= 1'b0;
        if (rst || !active) begin
            cnt_q     <= '0;
            sh_q      <= '0;
            sel_q     <= 1'b0;
            chan_q    <= '0;
            op_q      <= '0;
            slot_q    <= '0;
            rd_byte_q <= '0;
            miso_q    <= 1'b0;
            cmd       <= '0;
        end else if (run && sck_rise && cnt_q != FULL) begin
            sh_q  <= sh_nxt;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == BYTE1_END) begin
                sel_q  <= (sh_nxt[7:4] == DEV_CODE) && (sh_nxt[3:2] == dev_addr);
                chan_q <= sh_nxt[1:0];
            end
            if (cnt_q == BYTE2_END) begin
                op_q      <= sh_nxt[7:4];
                slot_q    <= sh_nxt[1:0];
                rd_byte_q <= 8'(rd_data);
                miso_q    <= 1'b0;
            end
            if (cnt_q == LAST_BIT) begin
                cmd_valid <= sel_q;
                cmd       <= '{chan: chan_q, op: op_q, slot: slot_q, data: sh_nxt[5:0]};
            end
        end else if (run && sck_fall && cnt_q >= BYTE3_BEG && cnt_q != FULL) begin
            miso_q <= rd_byte_q[3'd7 - out_idx];
        end
    end

    assign miso    = miso_q;
    assign miso_oe = run && sel_q && (cnt_q >= BYTE3_BEG) && op_is_read(op_q);

endmodule

// File: rtl/wpc_regs.sv
module wpc_regs
    import wpc_pkg::*;
#(
    parameter int NCH         = DEF_NCH,
    parameter int NSLOT       = DEF_NSLOT,
    parameter int WBITS       = DEF_WBITS,
    parameter int BUSY_CYCLES = 1000,
    parameter int NV_INIT     = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wp_n,
    input  logic                        cmd_valid,
    input  wpc_cmd_t                    cmd,
    input  logic [1:0]                  look_chan,
    input  logic [3:0]                  look_op,
    input  logic [1:0]                  look_slot,
    output logic [WBITS-1:0]            rd_data,
    output logic [NCH-1:0][WBITS-1:0]   wiper,
    output logic                        busy
);

    localparam int BW = $clog2(BUSY_CYCLES + 1);
    localparam logic [BW-1:0] BUSY_LOAD = BW'(BUSY_CYCLES);

    logic [NCH-1:0][WBITS-1:0] wiper_q;
    logic [WBITS-1:0]          nv_q [NCH][NSLOT] = '{default: '{default: WBITS'(NV_INIT)}};
    logic [BW-1:0]             busy_cnt;
    logic                      nv_ok;

    assign nv_ok = wp_n && (busy_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCH; c++) wiper_q[c] <= nv_q[c][0];
            busy_cnt <= '0;
        end else begin
            if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
            if (cmd_valid) begin
                case (cmd.op)
                    OP_WR_WIPER: wiper_q[cmd.chan] <= WBITS'(cmd.data);
                    OP_RECALL:   wiper_q[cmd.chan] <= nv_q[cmd.chan][cmd.slot];
                    OP_LOAD_ALL: for (int c = 0; c < NCH; c++) wiper_q[c] <= nv_q[c][cmd.slot];
                    OP_WR_SLOT: if (nv_ok) begin
                        nv_q[cmd.chan][cmd.slot] <= WBITS'(cmd.data);
                        busy_cnt                 <= BUSY_LOAD;
                    end
                    OP_SAVE: if (nv_ok) begin
                        nv_q[cmd.chan][cmd.slot] <= wiper_q[cmd.chan];
                        busy_cnt                 <= BUSY_LOAD;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        if (look_op == OP_RD_WIPER) rd_data = wiper_q[look_chan];
        else                        rd_data = nv_q[look_chan][look_slot];
    end

    assign wiper = wiper_q;
    assign busy  = (busy_cnt != '0);

endmodule

// File: rtl/wpc_tap_decode.sv
module wpc_tap_decode #(
    parameter int WBITS = 6,
    localparam int NTAPS = 1 << WBITS
) (
    input  logic [WBITS-1:0] code,
    output logic [NTAPS-1:0] onehot
);

    always_comb begin
        onehot       = '0;
        onehot[code] = 1'b1;
    end

endmodule

// File: rtl/quad_wiper_ctrl.sv
module quad_wiper_ctrl
    import wpc_pkg::*;
#(
    parameter int NCH         = DEF_NCH,
    parameter int NSLOT       = DEF_NSLOT,
    parameter int WBITS       = DEF_WBITS,
    parameter int BUSY_CYCLES = 1000,
    parameter int NV_INIT     = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          spi_sck,
    input  logic                          spi_cs_n,
    input  logic                          spi_mosi,
    input  logic                          spi_hold_n,
    input  logic                          wp_n,
    input  logic [1:0]                    dev_addr,
    output logic                          spi_miso,
    output logic                          spi_miso_oe,
    output logic                          nv_busy,
    output logic [NCH*WBITS-1:0]          wiper_codes,
    output logic [NCH*(1<<WBITS)-1:0]     tap_sel
);

    localparam int NTAPS = 1 << WBITS;

    logic                      cmd_valid;
    wpc_cmd_t                  cmd;
    logic [1:0]                look_chan, look_slot;
    logic [3:0]                look_op;
    logic [WBITS-1:0]          rd_data;
    logic [NCH-1:0][WBITS-1:0] wiper;

    wpc_spi_front #(.WBITS(WBITS)) u_front (
        .clk       (clk),
        .rst       (rst),
        .sck       (spi_sck),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .hold_n    (spi_hold_n),
        .dev_addr  (dev_addr),
        .rd_data   (rd_data),
        .look_chan (look_chan),
        .look_op   (look_op),
        .look_slot (look_slot),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .miso      (spi_miso),
        .miso_oe   (spi_miso_oe)
    );

    wpc_regs #(
        .NCH(NCH), .NSLOT(NSLOT), .WBITS(WBITS),
        .BUSY_CYCLES(BUSY_CYCLES), .NV_INIT(NV_INIT)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wp_n      (wp_n),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .look_chan (look_chan),
        .look_op   (look_op),
        .look_slot (look_slot),
        .rd_data   (rd_data),
        .wiper     (wiper),
        .busy      (nv_busy)
    );

    assign wiper_codes = wiper;

    for (genvar c = 0; c < NCH; c++) begin : g_tap
        wpc_tap_decode #(.WBITS(WBITS)) u_dec (
            .code   (wiper[c]),
            .onehot (tap_sel[c*NTAPS +: NTAPS])
        );
    end

endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
    parameter int NCH   = 4,
    parameter int WBITS = 6,
    localparam int NTAPS = 1 << WBITS
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     spi_cs_n,
    input logic                     spi_hold_n,
    input logic                     wp_n,
    input logic                     spi_miso_oe,
    input logic                     nv_busy,
    input logic                     cmd_valid,
    input logic [NCH*WBITS-1:0]     wiper_codes,
    input logic [NCH*NTAPS-1:0]     tap_sel
);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        a_r12_tap_onehot: assert property (@(posedge clk) disable iff (rst)
            ($countones(tap_sel[c*NTAPS +: NTAPS]) == 1) &&
            tap_sel[c*NTAPS + int'(wiper_codes[c*WBITS +: WBITS])]);
    end

    // R10, R2, R13: no completed command, no wiper movement
    a_r10_idle_wipers_hold: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> $stable(wiper_codes));

    a_r2_oe_needs_select: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2)) |-> !spi_miso_oe);

    a_r9_hold_tristate: assert property (@(posedge clk) disable iff (rst)
        (!spi_hold_n && $past(!spi_hold_n) && $past(!spi_hold_n, 2)) |-> !spi_miso_oe);

    a_r8_busy_from_command: assert property (@(posedge clk) disable iff (rst)
        $rose(nv_busy) |-> $past(cmd_valid));

    a_r7_protect_no_busy: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !wp_n) |=> !$rose(nv_busy));

endmodule

bind quad_wiper_ctrl wpc_checker #(.NCH(NCH), .WBITS(WBITS)) u_wpc_checker (.*);

// File: tb/test_quad_wiper_ctrl.sv
module test_quad_wiper_ctrl;

    localparam int NCH   = 4;
    localparam int WBITS = 6;
    localparam int NTAPS = 1 << WBITS;
    localparam int BUSY  = 600;
    localparam int HALF  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic [1:0] dev_addr = 2'b10;
    logic miso, oe, nv_busy;
    logic [NCH*WBITS-1:0] wiper_codes;
    logic [NCH*NTAPS-1:0] tap_sel;

    always #5 clk = ~clk;

    quad_wiper_ctrl #(.BUSY_CYCLES(BUSY), .NV_INIT(32)) i_quad_wiper_ctrl (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_hold_n(hold_n), .wp_n(wp_n), .dev_addr(dev_addr),
        .spi_miso(miso), .spi_miso_oe(oe), .nv_busy(nv_busy),
        .wiper_codes(wiper_codes), .tap_sel(tap_sel)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int wip(input int ch);
        return int'(wiper_codes[ch*WBITS +: WBITS]);
    endfunction

    // One frame; nbits < 24 aborts, hold_at >= 0 pauses before that bit
    task automatic xfer(input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3,
                        input bit m3, input int nbits, input int hold_at,
                        output logic [7:0] rd, output bit oe_seen, output bit oe_hold);
        logic [23:0] f;
        f = {b1, b2, b3};
        rd = '0; oe_seen = 1'b0; oe_hold = 1'b0;
        @(negedge clk); sck = m3;
        repeat (2) @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            if (i == hold_at) begin
                hold_n = 1'b0;
                repeat (4) @(negedge clk);
                for (int k = 0; k < 3; k++) begin
                    sck = ~sck; mosi = ~mosi;
                    repeat (HALF) @(negedge clk);
                    sck = ~sck;
                    repeat (HALF) @(negedge clk);
                end
                if (oe) oe_hold = 1'b1;
                hold_n = 1'b1;
                repeat (4) @(negedge clk);
            end
            if (m3) sck = 1'b0;
            mosi = f[23-i];
            repeat (HALF) @(negedge clk);
            if (i >= 16) begin
                rd = {rd[6:0], miso};
                if (oe) oe_seen = 1'b1;
            end
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            if (!m3) sck = 1'b0;
        end
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (nv_busy && n < 2 * BUSY) begin @(negedge clk); n++; end
    endtask

    typedef struct packed {
        logic [7:0] b1, b2, b3;
        logic       rd_chk;
        logic [7:0] rd_exp;
        logic [1:0] ch;
        logic [5:0] wexp;
        logic [3:0] req;
    } vec_t;

    // byte1 = 0101_10_cc for dev_addr 10
    localparam vec_t VECS [16] = '{
        '{8'h58, 8'hA0, 8'h05, 1'b0, 8'h00, 2'd0, 6'd5,  4'd3},  // R3 write wiper
        '{8'h58, 8'h90, 8'h00, 1'b1, 8'h05, 2'd0, 6'd5,  4'd3},  // R3 read wiper
        '{8'h5B, 8'hA0, 8'h3F, 1'b0, 8'h00, 2'd3, 6'd63, 4'd12}, // R12 top code
        '{8'h5B, 8'h90, 8'h00, 1'b1, 8'h3F, 2'd3, 6'd63, 4'd11}, // R11 mode 3 read
        '{8'h59, 8'hC2, 8'h11, 1'b0, 8'h00, 2'd1, 6'd32, 4'd4},  // R4 stored write
        '{8'h59, 8'hB2, 8'h00, 1'b1, 8'h11, 2'd1, 6'd32, 4'd4},  // R4 stored read
        '{8'h59, 8'hD2, 8'h00, 1'b0, 8'h00, 2'd1, 6'd17, 4'd5},  // R5 recall
        '{8'h5A, 8'hA0, 8'h00, 1'b0, 8'h00, 2'd2, 6'd0,  4'd12}, // R12 code 0
        '{8'h5A, 8'hE3, 8'h00, 1'b0, 8'h00, 2'd2, 6'd0,  4'd5},  // R5 save
        '{8'h5A, 8'hB3, 8'h00, 1'b1, 8'h00, 2'd2, 6'd0,  4'd5},  // R5 saved value
        '{8'h58, 8'h12, 8'h00, 1'b0, 8'h00, 2'd1, 6'd17, 4'd6},  // R6 load all slot 2
        '{8'h58, 8'h90, 8'h00, 1'b1, 8'h20, 2'd0, 6'd32, 4'd6},  // R6 ch0 reloaded
        '{8'h58, 8'h70, 8'h09, 1'b0, 8'h00, 2'd0, 6'd32, 4'd13}, // R13 unknown op
        '{8'h54, 8'hA0, 8'h09, 1'b0, 8'h00, 2'd0, 6'd32, 4'd2},  // R2 address mismatch
        '{8'h54, 8'h90, 8'h00, 1'b0, 8'h00, 2'd0, 6'd32, 4'd2},  // R2 mismatch read, no oe
        '{8'hA8, 8'hA0, 8'h09, 1'b0, 8'h00, 2'd0, 6'd32, 4'd2}   // R2 wrong device code
    };

    initial begin
        logic [7:0] rd;
        bit os, oh;
        string tag;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 / R12 reset state
        for (int c = 0; c < NCH; c++) chk(wip(c) == 32, "R1 reset wiper", wip(c), 32);
        chk(tap_sel[32] == 1'b1, "R12 tap bit", int'(tap_sel[32]), 1);
        chk(oe == 1'b0 && nv_busy == 1'b0, "R2 idle outputs", int'({oe, nv_busy}), 0);

        // Vector table, alternating mode 0 / mode 3 (R11)
        for (int i = 0; i < 16; i++) begin
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            xfer(VECS[i].b1, VECS[i].b2, VECS[i].b3, i[0], 24, -1, rd, os, oh);
            wait_idle();
            chk(wip(int'(VECS[i].ch)) == int'(VECS[i].wexp), tag, wip(int'(VECS[i].ch)), int'(VECS[i].wexp));
            if (VECS[i].rd_chk)
                chk(os && rd == VECS[i].rd_exp, tag, int'(rd), int'(VECS[i].rd_exp));
            else
                chk(!os, {tag, " oe"}, int'(os), 0);
        end

        // R1: stored contents survive reset, wipers reload from slot 0
        xfer(8'h58, 8'hC0, 8'h07, 1'b0, 24, -1, rd, os, oh); wait_idle();
        xfer(8'h5B, 8'hC0, 8'h32, 1'b1, 24, -1, rd, os, oh); wait_idle();
        xfer(8'h59, 8'hA0, 8'h09, 1'b0, 24, -1, rd, os, oh);
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk); rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(wip(0) == 7,  "R1 ch0 restore", wip(0), 7);
        chk(wip(1) == 32, "R1 ch1 restore", wip(1), 32);
        chk(wip(3) == 50, "R1 ch3 restore", wip(3), 50);
        xfer(8'h59, 8'hB2, 8'h00, 1'b0, 24, -1, rd, os, oh);
        chk(rd == 8'h11, "R1 slot kept", int'(rd), 17);

        // R7: write protect
        wp_n = 1'b0;
        xfer(8'h5A, 8'hC1, 8'h09, 1'b0, 24, -1, rd, os, oh);
        chk(nv_busy == 1'b0, "R7 no busy", int'(nv_busy), 0);
        xfer(8'h5A, 8'hE0, 8'h00, 1'b1, 24, -1, rd, os, oh);
        xfer(8'h5A, 8'hA0, 8'h2C, 1'b0, 24, -1, rd, os, oh);
        chk(wip(2) == 44, "R7 wiper write", wip(2), 44);
        wp_n = 1'b1;
        xfer(8'h5A, 8'hB1, 8'h00, 1'b0, 24, -1, rd, os, oh);
        chk(rd == 8'h20, "R7 slot1 kept", int'(rd), 32);
        xfer(8'h5A, 8'hB0, 8'h00, 1'b1, 24, -1, rd, os, oh);
        chk(rd == 8'h20, "R7 save dropped", int'(rd), 32);

        // R8: busy window rejects a second stored write
        xfer(8'h5A, 8'hC1, 8'h0B, 1'b0, 24, -1, rd, os, oh);
        chk(nv_busy == 1'b1, "R8 busy set", int'(nv_busy), 1);
        xfer(8'h5A, 8'hC0, 8'h0C, 1'b1, 24, -1, rd, os, oh);
        begin
            int n = 0;
            while (nv_busy && n < 2 * BUSY) begin @(negedge clk); n++; end
            chk(n < BUSY, "R8 busy ends", n, BUSY);
        end
        xfer(8'h5A, 8'hB1, 8'h00, 1'b0, 24, -1, rd, os, oh);
        chk(rd == 8'h0B, "R8 first write", int'(rd), 11);
        xfer(8'h5A, 8'hB0, 8'h00, 1'b1, 24, -1, rd, os, oh);
        chk(rd == 8'h20, "R8 second rejected", int'(rd), 32);

        // R10: abort before the last bit
        xfer(8'h59, 8'hA0, 8'h03, 1'b0, 20, -1, rd, os, oh);
        chk(wip(1) == 32, "R10 abort 20", wip(1), 32);
        xfer(8'h59, 8'hA0, 8'h03, 1'b1, 23, -1, rd, os, oh);
        chk(wip(1) == 32, "R10 abort 23", wip(1), 32);

        // R9: hold pauses the frame
        xfer(8'h59, 8'hA0, 8'h15, 1'b0, 24, 10, rd, os, oh);
        chk(wip(1) == 21, "R9 write through hold", wip(1), 21);
        xfer(8'h59, 8'h90, 8'h00, 1'b1, 24, 19, rd, os, oh);
        chk(rd == 8'h15, "R9 read through hold", int'(rd), 21);
        chk(!oh, "R9 oe low in hold", int'(oh), 0);

        // R6: load all from slot 0, channel field ignored
        xfer(8'h5B, 8'h10, 8'h00, 1'b0, 24, -1, rd, os, oh);
        chk(wip(0) == 7,  "R6 ch0", wip(0), 7);
        chk(wip(3) == 50, "R6 ch3", wip(3), 50);
        chk(tap_sel[3*NTAPS + 50] == 1'b1, "R12 ch3 tap", int'(tap_sel[3*NTAPS + 50]), 1);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule